// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit I/O virtual address into a physical address by fetching two entries from memory. The top twelve address bits select a word in a first-level directory whose base is supplied on `table_base`. That word, when valid, points at a second-level table. Bits 19:12 select a word in that table. The second-level word gives the physical page and a 4-bit access-control index. The low twelve bits pass through unchanged as the page offset.

The block serves one translation at a time. The memory side is a read port with at most one request in flight: a one-cycle request pulse, then a response whenever the memory is ready. A bad entry at either level ends the walk with a faulted response. It also sets a sticky status flag for that level. The walker keeps the faulting address and a per-master blame vector for each level until software clears the flag.

Top module: `pt_walker2`

## Requirements
- R1: After reset `req_ready` is 1, `mem_req_valid` and `rsp_valid` are 0, and `flt_sts`, both blame vectors and both fault addresses are 0.
- R2: The first fetch of a walk reads address `table_base + iova[31:20]*4`.
- R3: A directory word is valid only when its bits 1:0 equal 2'b01. Any other value ends the walk with a level-one fault. On that fault, `flt_sts[0]` is set, `l1_flt_addr` takes the request address, and bit `req_master` of `l1_blame` is set. No second fetch is issued.
- R4: The second fetch reads the directory word with bits 9:0 forced to zero, plus `iova[19:12]*4`. Any reserved bits 9:2 in the directory word do not change this address.
- R5: A page word is valid only when bit 1 is set. Otherwise the walk ends with a level-two fault. On that fault, `flt_sts[1]` is set, `l2_flt_addr` takes the request address, and bit `req_master` of `l2_blame` is set.
- R6: A successful walk gives a one-cycle `rsp_valid` with `rsp_fault`=0. `rsp_pa` is {page word bits 31:12, iova bits 11:0}, and `rsp_aci` is page word bits 7:4.
- R7: Each level issues exactly one single-cycle `mem_req_valid` pulse. `req_ready` stays low from the cycle after a request is accepted until the walk's response.
- R8: Fault flags and blame bits are sticky. Further faults OR new blame bits in and overwrite that level's address. Asserting `flt_clr[i]` for one cycle clears `flt_sts[i]` and the blame vector for level i (bit 0 is level one, bit 1 is level two), leaving the other level untouched.
- R9: A faulted walk gives a one-cycle `rsp_valid` with `rsp_fault`=1, in the cycle the fault flag first reads as set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| table_base | input | 32 | Base address of the first-level directory |
| req_valid | input | 1 | Translation request |
| req_iova | input | 32 | Virtual address to translate |
| req_master | input | MIW | Index of the requesting master |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| mem_req_valid | output | 1 | One-cycle memory read request |
| mem_req_addr | output | 32 | Read address for the memory request |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Returned table word |
| rsp_valid | output | 1 | Walk finished (one cycle) |
| rsp_fault | output | 1 | Walk ended on an invalid entry |
| rsp_pa | output | 32 | Translated physical address |
| rsp_aci | output | 4 | Access-control index of the page |
| flt_clr | input | 2 | Per-level fault clear |
| flt_sts | output | 2 | Sticky fault flags, bit 0 level one, bit 1 level two |
| l1_flt_addr | output | 32 | Address of the latest level-one fault |
| l2_flt_addr | output | 32 | Address of the latest level-two fault |
| l1_blame | output | NMAST | Masters that hit a level-one fault |
| l2_blame | output | NMAST | Masters that hit a level-two fault |

## Verification
Addresses at the first and last directory index show whether the first-level index is scaled and added correctly. Directory words with low bits 00, 10 and 11 are each expected to fault. A word with low bits 01 and all reserved bits set shows that the pointer is masked before the second fetch. Page words with only bit 0 set, or with bit 1 clear, separate the true valid bit from its neighbour. Offsets of 0x000, 0x123 and 0xFFF, with varying memory latency, show that the offset is passed through and that the walker waits on the response. Back-to-back faults without a clear, followed by a clear of one level only, check blame accumulation and per-level independence.

// File: rtl/pt_walker2.sv
module pt_walker2 #(
  parameter int NMAST = 6,
  parameter int MIW   = (NMAST > 1) ? $clog2(NMAST) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      table_base,
  input  logic             req_valid,
  input  logic [31:0]      req_iova,
  input  logic [MIW-1:0]   req_master,
  output logic             req_ready,
  output logic             mem_req_valid,
  output logic [31:0]      mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [31:0]      mem_rsp_data,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [31:0]      rsp_pa,
  output logic [3:0]       rsp_aci,
  input  logic [1:0]       flt_clr,
  output logic [1:0]       flt_sts,
  output logic [31:0]      l1_flt_addr,
  output logic [31:0]      l2_flt_addr,
  output logic [NMAST-1:0] l1_blame,
  output logic [NMAST-1:0] l2_blame
);
  localparam int DIR_BITS = 12;
  localparam int PT_BITS  = 8;
  localparam int OFF_BITS = 32 - DIR_BITS - PT_BITS;

  typedef enum logic [2:0] {S_IDLE, S_RD_DTE, S_RD_PTE, S_DONE, S_FAULT} st_t;

  st_t         st;
  logic [31:0] va_q, dte_q, pte_q;
  logic [MIW-1:0] mst_q;
  logic        issued;

  wire [DIR_BITS-1:0] dir_idx = va_q[31 -: DIR_BITS];
  wire [PT_BITS-1:0]  pt_idx  = va_q[OFF_BITS +: PT_BITS];
  wire walking = (st == S_RD_DTE) || (st == S_RD_PTE);
  wire take    = walking && issued && mem_rsp_valid;
  wire dte_ok  = (mem_rsp_data[1:0] == 2'b01);
  wire pte_ok  = mem_rsp_data[1];
  wire l1_hit  = take && (st == S_RD_DTE) && !dte_ok;
  wire l2_hit  = take && (st == S_RD_PTE) && !pte_ok;
  wire [NMAST-1:0] mst_oh = NMAST'(1) << mst_q;

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = walking && !issued;
  assign mem_req_addr  = (st == S_RD_PTE)
    ? {dte_q[31:10], 10'b0} + {{(30-PT_BITS){1'b0}}, pt_idx, 2'b00}
    : table_base + {{(30-DIR_BITS){1'b0}}, dir_idx, 2'b00};
  assign rsp_valid = (st == S_DONE) || (st == S_FAULT);
  assign rsp_fault = (st == S_FAULT);
  assign rsp_pa    = {pte_q[31:OFF_BITS], va_q[OFF_BITS-1:0]};
  assign rsp_aci   = pte_q[7:4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; va_q <= '0; dte_q <= '0; pte_q <= '0; mst_q <= '0; issued <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q <= req_iova; mst_q <= req_master; issued <= 1'b0; pte_q <= '0; st <= S_RD_DTE;
        end
        S_RD_DTE, S_RD_PTE: begin
          if (!issued) issued <= 1'b1;
          else if (mem_rsp_valid) begin
            issued <= 1'b0;
            if (st == S_RD_DTE) begin
              if (dte_ok) begin dte_q <= mem_rsp_data; st <= S_RD_PTE; end
              else st <= S_FAULT;
            end else begin
              if (pte_ok) begin pte_q <= mem_rsp_data; st <= S_DONE; end
              else st <= S_FAULT;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_sts <= '0; l1_flt_addr <= '0; l2_flt_addr <= '0; l1_blame <= '0; l2_blame <= '0;
    end else begin
      flt_sts[0] <= l1_hit | (flt_sts[0] & ~flt_clr[0]);
      flt_sts[1] <= l2_hit | (flt_sts[1] & ~flt_clr[1]);
      l1_blame <= (l1_blame & ~{NMAST{flt_clr[0]}}) | (l1_hit ? mst_oh : '0);
      l2_blame <= (l2_blame & ~{NMAST{flt_clr[1]}}) | (l2_hit ? mst_oh : '0);
      if (l1_hit) l1_flt_addr <= va_q;
      if (l2_hit) l2_flt_addr <= va_q;
    end
  end

  p_req_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid);
  p_rsp_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_l1_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flt_sts[0]) |-> ($past(mem_rsp_valid) && $past(mem_rsp_data[1:0]) != 2'b01));
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_sts[1] && !flt_clr[1]) |=> flt_sts[1]);
  p_fault_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flt_sts[1]) |-> (rsp_valid && rsp_fault));
endmodule

// File: tb/pt_walker2_tb_top.sv
module pt_walker2_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 6;
  localparam logic [31:0] TTB = 32'h0010_0000;

  typedef struct packed {
    logic [31:0] va; logic [2:0] m; logic [1:0] lat; logic [1:0] sts;
    logic [31:0] pa; logic [3:0] aci; logic [1:0] nreq;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{32'h0010_5123, 3'd2, 2'd1, 2'b00, 32'hABCD_E123, 4'h3, 2'd2},
    '{32'h003F_FFFF, 3'd5, 2'd3, 2'b00, 32'h7654_3FFF, 4'hF, 2'd2},
    '{32'hFFF0_0000, 3'd0, 2'd2, 2'b01, 32'h0, 4'h0, 2'd1},
    '{32'h0020_0000, 3'd1, 2'd1, 2'b01, 32'h0, 4'h0, 2'd1},
    '{32'h0040_0ABC, 3'd3, 2'd2, 2'b01, 32'h0, 4'h0, 2'd1},
    '{32'h0010_6000, 3'd4, 2'd1, 2'b10, 32'h0, 4'h0, 2'd2},
    '{32'h0010_7FFF, 3'd0, 2'd3, 2'b10, 32'h0, 4'h0, 2'd2},
    '{32'h0010_5FFF, 3'd1, 2'd2, 2'b00, 32'hABCD_EFFF, 4'h3, 2'd2}
  };

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, mem_rsp_valid = 0;
  logic [31:0] req_iova = '0, mem_rsp_data = '0;
  logic [2:0] req_master = '0;
  logic [1:0] flt_clr = '0;
  logic req_ready, mem_req_valid, rsp_valid, rsp_fault;
  logic [31:0] mem_req_addr, rsp_pa, l1_flt_addr, l2_flt_addr;
  logic [3:0] rsp_aci;
  logic [1:0] flt_sts;
  logic [NM-1:0] l1_blame, l2_blame;

  int n_tests = 0, n_fail = 0, rsp_lat = 1, req_cnt = 0;
  logic [31:0] addr_log [2];
  logic [31:0] mem [logic [31:0]];

  pt_walker2 #(.NMAST(NM)) dut_i (
    .clk, .rst_n, .table_base(TTB), .req_valid, .req_iova, .req_master, .req_ready,
    .mem_req_valid, .mem_req_addr, .mem_rsp_valid, .mem_rsp_data,
    .rsp_valid, .rsp_fault, .rsp_pa, .rsp_aci, .flt_clr, .flt_sts,
    .l1_flt_addr, .l2_flt_addr, .l1_blame, .l2_blame);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    mem_rsp_valid = 0;
    if (mem_req_valid) begin
      if (req_cnt < 2) addr_log[req_cnt] = mem_req_addr;
      req_cnt++;
      repeat (rsp_lat) @(negedge clk);
      mem_rsp_valid = 1;
      mem_rsp_data = rd(addr_log[(req_cnt > 2) ? 1 : req_cnt-1]);
    end
  end

  task automatic walk(input logic [31:0] va, input logic [2:0] m, input int lat);
    int n = 0;
    rsp_lat = lat; req_cnt = 0;
    @(negedge clk); req_valid = 1; req_iova = va; req_master = m;
    @(negedge clk); req_valid = 0;
    chk("R7 busy", {31'b0, req_ready}, 32'h0);
    while (!rsp_valid && n < 200) begin @(negedge clk); n++; end
    if (n >= 200) chk("R7 no response", 32'h1, 32'h0);
  endtask

  task automatic clear(input logic [1:0] c);
    @(negedge clk); flt_clr = c;
    @(negedge clk); flt_clr = '0;
  endtask

  initial begin
    mem[TTB + 32'h4]    = 32'h0020_0001;
    mem[32'h0020_0014]  = 32'hABCD_E032;
    mem[32'h0020_0018]  = 32'h1111_1030;
    mem[32'h0020_001C]  = 32'h1234_5001;
    mem[32'h0020_0014 + 32'h0] = 32'hABCD_E032;
    mem[TTB + 32'h3FFC] = 32'h0030_0003;
    mem[TTB + 32'h8]    = 32'h0040_0002;
    mem[TTB + 32'hC]    = 32'h0050_03FD;
    mem[32'h0050_03FC]  = 32'h7654_3FF2;

    repeat (3) @(negedge clk);
    chk("R1 ready", {31'b0, req_ready}, 32'h1);
    chk("R1 memreq", {31'b0, mem_req_valid}, 32'h0);
    chk("R1 rsp", {31'b0, rsp_valid}, 32'h0);
    chk("R1 sts", {30'b0, flt_sts}, 32'h0);
    chk("R1 blame", {20'b0, l1_blame, l2_blame}, 32'h0);
    chk("R1 addr", l1_flt_addr | l2_flt_addr, 32'h0);
    rst_n = 1;

    for (int i = 0; i < 8; i++) begin
      logic [31:0] a1, a2;
      walk(VEC[i].va, VEC[i].m, int'(VEC[i].lat));
      a1 = TTB + {18'b0, VEC[i].va[31:20], 2'b00};
      chk("R2 dir fetch addr", addr_log[0], a1);
      chk("R7 fetch count", req_cnt, {30'b0, VEC[i].nreq});
      if (VEC[i].nreq == 2) begin
        a2 = (rd(a1) & 32'hFFFF_FC00) + {22'b0, VEC[i].va[19:12], 2'b00};
        chk("R4 page fetch addr", addr_log[1], a2);
      end
      chk("R9 fault flag", {31'b0, rsp_fault}, {31'b0, VEC[i].sts != 2'b00});
      chk("R8 status", {30'b0, flt_sts}, {30'b0, VEC[i].sts});
      if (VEC[i].sts == 2'b00) begin
        chk("R6 pa", rsp_pa, VEC[i].pa);
        chk("R6 aci", {28'b0, rsp_aci}, {28'b0, VEC[i].aci});
      end else if (VEC[i].sts == 2'b01) begin
        chk("R3 addr", l1_flt_addr, VEC[i].va);
        chk("R3 blame", {26'b0, l1_blame}, {26'b0, NM'(1) << VEC[i].m});
      end else begin
        chk("R5 addr", l2_flt_addr, VEC[i].va);
        chk("R5 blame", {26'b0, l2_blame}, {26'b0, NM'(1) << VEC[i].m});
      end
      @(negedge clk);
      chk("R6 rsp one cycle", {31'b0, rsp_valid}, 32'h0);
      clear(2'b11);
      chk("R8 cleared", {30'b0, flt_sts}, 32'h0);
    end

    walk(32'hFFF0_0000, 3'd0, 1);
    walk(32'h0020_0000, 3'd3, 2);
    chk("R8 blame accumulates", {26'b0, l1_blame}, 32'h09);
    chk("R8 addr latest", l1_flt_addr, 32'h0020_0000);
    walk(32'h0010_6000, 3'd5, 1);
    chk("R8 both levels", {30'b0, flt_sts}, 32'h3);
    clear(2'b01);
    chk("R8 clear level one only", {30'b0, flt_sts}, 32'h2);
    chk("R8 l1 blame cleared", {26'b0, l1_blame}, 32'h0);
    chk("R8 l2 blame kept", {26'b0, l2_blame}, 32'h20);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule